// File: doc/BRIEF.md
# Double-Data-Rate Prefetch Data Path

This block sits between a core that moves one 2n-bit word per core clock and a pin interface that moves one n-bit beat per half clock. One core clock is modelled as two cycles of a fast clock, `clk2x`, so every half-cycle phase of the pin interface is one `clk2x` cycle.

On the write side a word and its byte masks are split into two beats. The lower half goes out first and the upper half second. A write strobe is generated whose edges fall in the middle of each beat. The strobe is framed by a low preamble and a low postamble, and it is released (enable low) outside the burst. The burst length code selects 1, 2 or 4 words (2, 4 or 8 beats), and the block fetches each following word from the core through a request flag.

On the read side the incoming strobe is edge-aligned with the data. Beats are captured at both strobe edges: the rising edge captures the lower half and the falling edge the upper half. Each completed pair is handed to the core as one word with a valid flag lasting one core clock.

The write state machine has five states:
- `W_IDLE`: goes to `W_PRE` on `wr_start`.
- `W_PRE`: goes to `W_LO` unconditionally.
- `W_LO`: goes to `W_HI` unconditionally.
- `W_HI`: goes to `W_LO` while words remain, and to `W_POST` after the last word.
- `W_POST`: goes to `W_IDLE` unconditionally.

The read state machine has three states:
- `R_OFF`: goes to `R_LO` when `rd_en` is high.
- `R_LO`: goes to `R_HI` on a rising strobe edge.
- `R_HI`: goes to `R_LO` on a falling strobe edge.
- From `R_LO` or `R_HI`, the machine returns to `R_OFF` whenever `rd_en` is low.

Top module: `ddr_beat_path`

## Requirements
- R1: After reset, `pin_dq_oe`, `pin_dqs_oe`, `pin_dqs`, `wr_next` and `rd_valid` are all 0.
- R2: One `clk2x` cycle after `wr_start` is taken, there is one cycle with `pin_dqs_oe`=1, `pin_dqs`=0 and `pin_dq_oe`=0 (preamble) before the first beat.
- R3: Each word is sent as two beats, bits [n-1:0] first and bits [2n-1:n] second. `wr_mask` bits [m-1:0] go with the first beat and bits [2m-1:m] with the second. `pin_dm` bit i covers `pin_dq` byte i, and a 1 marks that byte as blocked.
- R4: `pin_dqs` is low in the first half of the first beat of each word, rises in its middle, and falls in the middle of the second beat.
- R5: `wr_bl` selects the burst: 0 gives 1 word, 1 gives 2 words, and 2 or 3 give 4 words.
- R6: `wr_next` is 1 during the second beat of every word except the last; `wr_word`/`wr_mask` are sampled at the end of that cycle.
- R7: After the last beat there is one cycle with `pin_dqs_oe`=1, `pin_dqs`=0 and `pin_dq_oe`=0 (postamble); after that, both enables are 0.
- R8: `wr_start` has no effect while a burst is in progress; the burst keeps its length.
- R9: With `rd_en`=1, a rising `rd_dqs` edge captures `rd_dq` as the lower half and the next falling edge as the upper half of `rd_word`.
- R10: `rd_valid` is 1 for exactly two `clk2x` cycles after each captured pair. With back-to-back pairs it stays 1 and `rd_word` advances.
- R11: With `rd_en`=0, strobe edges capture nothing. Dropping `rd_en` between the two beats of a pair discards the half pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock, two cycles per core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Begin a write burst (taken in `W_IDLE`) |
| wr_bl | input | 2 | Burst length code |
| wr_word | input | 2*BEAT_W | Write word from the core |
| wr_mask | input | 2*BEAT_W/BYTE_W | Byte masks for both beats of the word |
| wr_next | output | 1 | Next word is sampled at the end of this cycle |
| pin_dq | output | BEAT_W | Write beat data |
| pin_dm | output | BEAT_W/BYTE_W | Write beat byte mask |
| pin_dq_oe | output | 1 | Data pins driven |
| pin_dqs | output | 1 | Write strobe, centred in each beat |
| pin_dqs_oe | output | 1 | Strobe driven |
| rd_en | input | 1 | Read capture window |
| rd_dqs | input | 1 | Incoming read strobe, edge-aligned with data |
| rd_dq | input | BEAT_W | Incoming read beat |
| rd_word | output | 2*BEAT_W | Reassembled read word |
| rd_valid | output | 1 | `rd_word` is valid (one core clock) |

## Verification
The hardest situation to reach from the ports is a read pair split by a drop of `rd_en`. Reaching it needs the lower beat already latched and the machine waiting in `R_HI`, and then a lone falling edge arriving after the window reopens. The bench drives a rising edge, drops and reraises `rd_en` while holding the strobe high, and then delivers the falling edge. It checks that no word appears, and that the next full pair produces a fresh word with no stale half. On the write side, the word fetch is reached by answering `wr_next` inside the second beat while `wr_start` is held high throughout the burst, which shows that the restart request is ignored.

// File: rtl/ddr_beat_pkg.sv
package ddr_beat_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_PRE,
        W_LO,
        W_HI,
        W_POST
    } wr_state_t;

    typedef enum logic [1:0] {
        R_OFF,
        R_LO,
        R_HI
    } rd_state_t;

    // words per burst for a burst length code
    function automatic logic [2:0] words_for_code(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ddr_wr_serializer.sv
module ddr_wr_serializer
    import ddr_beat_pkg::*;
#(
    parameter int BEAT_W = 16,
    parameter int MASK_W = 2
) (
    input  logic                  clk2x,
    input  logic                  rst_n,
    input  logic                  wr_start,
    input  logic [1:0]            wr_bl,
    input  logic [2*BEAT_W-1:0]   wr_word,
    input  logic [2*MASK_W-1:0]   wr_mask,
    output logic                  wr_next,
    output logic [BEAT_W-1:0]     pin_dq,
    output logic [MASK_W-1:0]     pin_dm,
    output logic                  pin_dq_oe,
    output logic                  pin_dqs_oe,
    output logic                  strobe_hi_req
);

    wr_state_t                 state, nxt;
    logic [2*BEAT_W-1:0]       wbuf;
    logic [2*MASK_W-1:0]       mbuf;
    logic [1:0]                remain;

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            W_IDLE: if (wr_start) nxt = W_PRE;
            W_PRE:  nxt = W_LO;
            W_LO:   nxt = W_HI;
            W_HI:   nxt = (remain != 2'd0) ? W_LO : W_POST;
            W_POST: nxt = W_IDLE;
            default: nxt = W_IDLE;
        endcase
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            wbuf   <= '0;
            mbuf   <= '0;
            remain <= '0;
        end else if (state == W_IDLE && wr_start) begin
            wbuf   <= wr_word;
            mbuf   <= wr_mask;
            remain <= 2'(words_for_code(wr_bl) - 3'd1);
        end else if (state == W_HI && remain != 2'd0) begin
            wbuf   <= wr_word;
            mbuf   <= wr_mask;
            remain <= remain - 2'd1;
        end
    end

    always_comb begin
        wr_next       = 1'b0;
        pin_dq        = '0;
        pin_dm        = '0;
        pin_dq_oe     = 1'b0;
        pin_dqs_oe    = 1'b0;
        strobe_hi_req = 1'b0;
        unique case (state)
            W_IDLE: ;
            W_PRE:  pin_dqs_oe = 1'b1;
            W_LO: begin
                pin_dq        = wbuf[BEAT_W-1:0];
                pin_dm        = mbuf[MASK_W-1:0];
                pin_dq_oe     = 1'b1;
                pin_dqs_oe    = 1'b1;
                strobe_hi_req = 1'b1;
            end
            W_HI: begin
                pin_dq     = wbuf[2*BEAT_W-1:BEAT_W];
                pin_dm     = mbuf[2*MASK_W-1:MASK_W];
                pin_dq_oe  = 1'b1;
                pin_dqs_oe = 1'b1;
                wr_next    = (remain != 2'd0);
            end
            W_POST: pin_dqs_oe = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_strobe_gen.sv
module ddr_strobe_gen (
    input  logic clk2x,
    input  logic rst_n,
    input  logic strobe_hi_req,
    output logic pin_dqs
);

    // Falling edge of the fast clock sits in the middle of each beat,
    // so the strobe edges land centred in the data eye.
    always_ff @(negedge clk2x or negedge rst_n) begin
        if (!rst_n) pin_dqs <= 1'b0;
        else        pin_dqs <= strobe_hi_req;
    end

endmodule

// File: rtl/ddr_rd_deserializer.sv
module ddr_rd_deserializer
    import ddr_beat_pkg::*;
#(
    parameter int BEAT_W = 16
) (
    input  logic                clk2x,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic                rd_dqs,
    input  logic [BEAT_W-1:0]   rd_dq,
    output logic [2*BEAT_W-1:0] rd_word,
    output logic                rd_valid
);

    localparam logic [1:0] HOLD_CYC = 2'd2;

    rd_state_t         state, nxt;
    logic              dqs_d;
    logic              rise, fall;
    logic [BEAT_W-1:0] lo_buf;
    logic [1:0]        vcnt;

    assign rise = rd_dqs & ~dqs_d;
    assign fall = ~rd_dqs & dqs_d;

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) state <= R_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            R_OFF: if (rd_en) nxt = R_LO;
            R_LO:  if (!rd_en) nxt = R_OFF; else if (rise) nxt = R_HI;
            R_HI:  if (!rd_en) nxt = R_OFF; else if (fall) nxt = R_LO;
            default: nxt = R_OFF;
        endcase
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            dqs_d   <= 1'b0;
            lo_buf  <= '0;
            rd_word <= '0;
            vcnt    <= '0;
        end else begin
            dqs_d <= rd_dqs;
            if (state == R_LO && rd_en && rise)
                lo_buf <= rd_dq;
            if (state == R_HI && rd_en && fall) begin
                rd_word <= {rd_dq, lo_buf};
                vcnt    <= HOLD_CYC;
            end else if (vcnt != 2'd0) begin
                vcnt <= vcnt - 2'd1;
            end
        end
    end

    always_comb rd_valid = (vcnt != 2'd0);

endmodule

// File: rtl/ddr_beat_path.sv
module ddr_beat_path #(
    parameter int BEAT_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                             clk2x,
    input  logic                             rst_n,
    input  logic                             wr_start,
    input  logic [1:0]                       wr_bl,
    input  logic [2*BEAT_W-1:0]              wr_word,
    input  logic [2*(BEAT_W/BYTE_W)-1:0]     wr_mask,
    output logic                             wr_next,
    output logic [BEAT_W-1:0]                pin_dq,
    output logic [(BEAT_W/BYTE_W)-1:0]       pin_dm,
    output logic                             pin_dq_oe,
    output logic                             pin_dqs,
    output logic                             pin_dqs_oe,
    input  logic                             rd_en,
    input  logic                             rd_dqs,
    input  logic [BEAT_W-1:0]                rd_dq,
    output logic [2*BEAT_W-1:0]              rd_word,
    output logic                             rd_valid
);

    localparam int MASK_W = BEAT_W / BYTE_W;

    logic strobe_hi_req;

    ddr_wr_serializer #(.BEAT_W(BEAT_W), .MASK_W(MASK_W)) u_wr (
        .clk2x         (clk2x),
        .rst_n         (rst_n),
        .wr_start      (wr_start),
        .wr_bl         (wr_bl),
        .wr_word       (wr_word),
        .wr_mask       (wr_mask),
        .wr_next       (wr_next),
        .pin_dq        (pin_dq),
        .pin_dm        (pin_dm),
        .pin_dq_oe     (pin_dq_oe),
        .pin_dqs_oe    (pin_dqs_oe),
        .strobe_hi_req (strobe_hi_req)
    );

    ddr_strobe_gen u_stb (
        .clk2x         (clk2x),
        .rst_n         (rst_n),
        .strobe_hi_req (strobe_hi_req),
        .pin_dqs       (pin_dqs)
    );

    ddr_rd_deserializer #(.BEAT_W(BEAT_W)) u_rd (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_dqs   (rd_dqs),
        .rd_dq    (rd_dq),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/ddr_beat_path_chk.sv
module ddr_beat_path_chk (
    input logic clk2x,
    input logic rst_n,
    input logic wr_next,
    input logic pin_dq_oe,
    input logic pin_dqs,
    input logic pin_dqs_oe,
    input logic rd_valid
);

    p_preamble_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(pin_dqs_oe) |-> !pin_dq_oe && !pin_dqs);

    p_strobe_driven_r4: assert property (@(posedge clk2x) disable iff (!rst_n)
        pin_dqs |-> pin_dqs_oe);

    p_next_in_beat_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
        wr_next |-> pin_dq_oe);

    p_data_inside_strobe_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
        pin_dq_oe |-> pin_dqs_oe);

    p_postamble_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(pin_dq_oe) |-> pin_dqs_oe && !pin_dqs);

    p_valid_two_cycles_r10: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid);

endmodule

bind ddr_beat_path ddr_beat_path_chk u_chk (
    .clk2x      (clk2x),
    .rst_n      (rst_n),
    .wr_next    (wr_next),
    .pin_dq_oe  (pin_dq_oe),
    .pin_dqs    (pin_dqs),
    .pin_dqs_oe (pin_dqs_oe),
    .rd_valid   (rd_valid)
);

// File: tb/ddr_beat_path_test.sv
module ddr_beat_path_test;

    localparam int CLK_P  = 10;
    localparam int BEAT_W = 16;
    localparam int MASK_W = 2;

    logic                  clk2x = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_start = 1'b0;
    logic [1:0]            wr_bl = 2'd0;
    logic [2*BEAT_W-1:0]   wr_word = '0;
    logic [2*MASK_W-1:0]   wr_mask = '0;
    logic                  wr_next;
    logic [BEAT_W-1:0]     pin_dq;
    logic [MASK_W-1:0]     pin_dm;
    logic                  pin_dq_oe, pin_dqs, pin_dqs_oe;
    logic                  rd_en = 1'b0;
    logic                  rd_dqs = 1'b0;
    logic [BEAT_W-1:0]     rd_dq = '0;
    logic [2*BEAT_W-1:0]   rd_word;
    logic                  rd_valid;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] wv [4];
    logic [3:0]  mv [4];

    always #(CLK_P/2) clk2x = ~clk2x;

    ddr_beat_path #(.BEAT_W(BEAT_W), .BYTE_W(8)) uut (
        .clk2x(clk2x), .rst_n(rst_n), .wr_start(wr_start), .wr_bl(wr_bl),
        .wr_word(wr_word), .wr_mask(wr_mask), .wr_next(wr_next),
        .pin_dq(pin_dq), .pin_dm(pin_dm), .pin_dq_oe(pin_dq_oe),
        .pin_dqs(pin_dqs), .pin_dqs_oe(pin_dqs_oe), .rd_en(rd_en),
        .rd_dqs(rd_dqs), .rd_dq(rd_dq), .rd_word(rd_word), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P*50000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk2x);
        #1;
        chk("R1 dq_oe", pin_dq_oe, 0);
        chk("R1 dqs_oe", pin_dqs_oe, 0);
        chk("R1 dqs", pin_dqs, 0);
        chk("R1 wr_next", wr_next, 0);
        chk("R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk2x);
    endtask

    // one write burst; words from wv/mv; hold_start keeps wr_start high (R8)
    task automatic t_write(input logic [1:0] code, input int nwords, input bit hold_start);
        @(negedge clk2x);
        wr_start = 1'b1; wr_bl = code; wr_word = wv[0]; wr_mask = mv[0];
        @(posedge clk2x); #1;
        if (!hold_start) wr_start = 1'b0;
        chk("R2 pre dqs_oe", pin_dqs_oe, 1);
        chk("R2 pre dq_oe", pin_dq_oe, 0);
        chk("R2 pre dqs", pin_dqs, 0);
        @(negedge clk2x); #1;
        chk("R2 pre dqs mid", pin_dqs, 0);
        for (int k = 0; k < nwords; k++) begin
            @(posedge clk2x); #1;
            chk("R3 lo dq_oe", pin_dq_oe, 1);
            chk("R3 lo data", pin_dq, wv[k][15:0]);
            chk("R3 lo mask", pin_dm, mv[k][1:0]);
            chk("R4 lo first half", pin_dqs, 0);
            @(negedge clk2x); #1;
            chk("R4 lo mid rise", pin_dqs, 1);
            @(posedge clk2x); #1;
            chk("R3 hi data", pin_dq, wv[k][31:16]);
            chk("R3 hi mask", pin_dm, mv[k][3:2]);
            chk("R4 hi first half", pin_dqs, 1);
            chk("R6 wr_next", wr_next, (k < nwords-1) ? 1 : 0);
            if (k < nwords-1) begin
                wr_word = wv[k+1];
                wr_mask = mv[k+1];
            end
            @(negedge clk2x); #1;
            chk("R4 hi mid fall", pin_dqs, 0);
        end
        @(posedge clk2x); #1;
        wr_start = 1'b0;
        chk("R5 R7 post dq_oe", pin_dq_oe, 0);
        chk("R7 post dqs_oe", pin_dqs_oe, 1);
        chk("R7 post dqs", pin_dqs, 0);
        @(posedge clk2x); #1;
        chk("R7 R8 idle dqs_oe", pin_dqs_oe, 0);
        chk("R7 R8 idle dq_oe", pin_dq_oe, 0);
        @(negedge clk2x);
    endtask

    task automatic beat(input logic lvl, input logic [15:0] d);
        @(negedge clk2x);
        rd_dqs = lvl;
        rd_dq  = d;
    endtask

    task automatic t_read_stream();
        @(negedge clk2x); rd_en = 1'b1; rd_dqs = 1'b0;
        beat(1'b0, 16'h0);
        for (int k = 0; k < 3; k++) begin
            beat(1'b1, 16'h1100 + 16'(k));
            if (k > 0) begin
                @(posedge clk2x); #1;
                chk("R10 stream held", rd_valid, 1);
            end
            beat(1'b0, 16'hA0A0 + 16'(k));
            @(posedge clk2x); #1;
            chk("R9 R10 stream valid", rd_valid, 1);
            chk("R9 stream word", rd_word, {16'hA0A0 + 16'(k), 16'h1100 + 16'(k)});
        end
        @(posedge clk2x); #1;
        chk("R10 second cycle", rd_valid, 1);
        @(posedge clk2x); #1;
        chk("R10 drop", rd_valid, 0);
        @(negedge clk2x); rd_en = 1'b0;
    endtask

    task automatic t_read_gap();
        @(negedge clk2x); rd_en = 1'b1; rd_dqs = 1'b0;
        beat(1'b0, 16'h0);
        beat(1'b1, 16'h5A5A);
        beat(1'b1, 16'hFFFF);
        beat(1'b0, 16'hC3C3);
        @(posedge clk2x); #1;
        chk("R9 gap word", rd_word, 32'hC3C35A5A);
        chk("R10 gap valid", rd_valid, 1);
        repeat (2) @(posedge clk2x);
        #1;
        chk("R10 gap end", rd_valid, 0);
        @(negedge clk2x); rd_en = 1'b0;
    endtask

    task automatic t_read_disabled();
        @(negedge clk2x); rd_en = 1'b0; rd_dqs = 1'b0;
        for (int k = 0; k < 4; k++) begin
            beat(k[0] ? 1'b0 : 1'b1, 16'h7000 + 16'(k));
            @(posedge clk2x); #1;
            chk("R11 disabled", rd_valid, 0);
        end
        beat(1'b0, 16'h0);
    endtask

    task automatic t_read_abort();
        @(negedge clk2x); rd_en = 1'b1; rd_dqs = 1'b0;
        beat(1'b0, 16'h0);
        beat(1'b1, 16'hDEAD);
        @(negedge clk2x); rd_en = 1'b0;
        @(negedge clk2x); rd_en = 1'b1;
        beat(1'b0, 16'hBEEF);
        @(posedge clk2x); #1;
        chk("R11 lone fall", rd_valid, 0);
        @(posedge clk2x); #1;
        chk("R11 lone fall later", rd_valid, 0);
        beat(1'b1, 16'h1234);
        beat(1'b0, 16'h5678);
        @(posedge clk2x); #1;
        chk("R11 fresh valid", rd_valid, 1);
        chk("R11 fresh word", rd_word, 32'h56781234);
        @(negedge clk2x); rd_en = 1'b0;
        repeat (3) @(negedge clk2x);
    endtask

    initial begin
        t_reset();
        wv[0] = 32'hA1B2C3D4; wv[1] = 32'h0F0F1E1E;
        wv[2] = 32'h55AA33CC; wv[3] = 32'h98765432;
        mv[0] = 4'b0001; mv[1] = 4'b1000; mv[2] = 4'b0110; mv[3] = 4'b1111;
        t_write(2'd0, 1, 1'b0);
        t_write(2'd1, 2, 1'b0);
        t_write(2'd2, 4, 1'b0);
        t_write(2'd3, 4, 1'b1);
        t_write(2'd0, 1, 1'b1);
        t_read_stream();
        t_read_gap();
        t_read_disabled();
        t_read_abort();
        summary();
    end

endmodule